// File: doc/BRIEF.md
# PCM Mono Codec Link with Short or Long Frame Sync

This block is the clock-owning end of a mono PCM serial link to a codec. It advances through bit slots on a bit-clock enable, drives the frame sync line in one of two conventions and sends one sample per frame on its serial output. In the same frame it collects one sample from the serial input. A one-cycle pulse of the system clock on `bclk_en` stands for one bit clock. Each frame carries exactly one channel.

In short-sync mode the sync line is high for one slot and the sample starts in the slot after it, so data follows the falling sync edge. In long-sync mode the sync line rises together with the sample's first bit and stays high for 13 slots. Sample width (8 to 16 bits) and frame length are picked up at each frame start. The frame length is raised to the smallest legal value when it is set too low.

The transmit side is a valid/ready stream. `tx_ready` is high only in the `bclk_en` cycle that opens a frame, and it does not depend on `tx_valid`. A sample transfers when both are high in that cycle. If `tx_valid` is low then, the frame carries silence and nothing is consumed. The receive side has no back-pressure: `rx_data` holds its value until the next sample, but `rx_valid` is only a one-cycle strobe.

Top module: `pcm_sync_link`

## Requirements
- R1: While `rst_n` is low, `fs_out`, `sd_out` and `rx_valid` are 0.
- R2: With `long_mode`=0, `fs_out` is high for exactly slot 0 of each frame, and the sample MSB is in slot 1.
- R3: With `long_mode`=1, `fs_out` is high for slots 0 to 12 of each frame, and the sample MSB is in slot 0.
- R4: A sample of W bits is taken from `tx_data[W-1:0]` and sent MSB first, one bit per slot. W is `sample_bits` limited to the range 8 to 16.
- R5: The frame length in slots is `frame_bits`, raised to at least W+1 in short mode and to at least the larger of W and 13 in long mode.
- R6: `sd_out` is 0 in every slot that does not carry a sample bit.
- R7: `tx_ready` is 1 only in a `bclk_en` cycle that opens a frame. A frame opened without `tx_valid` sends all zeros.
- R8: `sd_in` is sampled at the `bclk_en` edge that ends each data slot. One clock after the edge that ends the LSB slot, `rx_valid` is high for one cycle and `rx_data` holds the W-bit sample MSB first, sign-extended to 16 bits.
- R9: Changes to `long_mode`, `sample_bits` or `frame_bits` take effect only at the next frame start.
- R10: No frame starts before the first `bclk_en` after reset, and slots advance only on `bclk_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bclk_en | input | 1 | One pulse per bit clock |
| long_mode | input | 1 | 0 short sync, 1 long sync |
| sample_bits | input | 5 | Requested sample width |
| frame_bits | input | 8 | Requested frame length in slots |
| tx_data | input | 16 | Transmit sample, right-aligned |
| tx_valid | input | 1 | Transmit sample offered |
| tx_ready | output | 1 | Frame opening; sample taken if valid |
| fs_out | output | 1 | Frame sync line |
| sd_out | output | 1 | Serial transmit data |
| sd_in | input | 1 | Serial receive data |
| rx_data | output | 16 | Last received sample, sign-extended |
| rx_valid | output | 1 | One-cycle strobe for a new rx_data |

## Verification
`fs_out` and `sd_out` take a new slot's value in the clock that follows the `bclk_en` edge. `tx_ready` is combinational in the `bclk_en` cycle itself. `rx_valid` and `rx_data` change one clock after the edge that closes the LSB slot; when the LSB sits in the last slot, that edge is the one that opens the next frame. The bench drives inputs on the falling edge and compares every output against a queue of per-slot expectations 1 ns later. Each queue is built from the settings in force at frame start. The serial line is looped back, so every transmitted sample is also checked as a received one.

// File: rtl/pcm_link_pkg.sv
package pcm_link_pkg;
  typedef enum logic {
    SYNC_SHORT = 1'b0,
    SYNC_LONG  = 1'b1
  } sync_mode_e;
endpackage

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
  import pcm_link_pkg::*;
#(
  parameter int unsigned SAMPLE_MIN = 8,
  parameter int unsigned SAMPLE_MAX = 16,
  parameter int unsigned LEN_W      = 8,
  parameter int unsigned LONG_SYNC  = 13,
  parameter int unsigned WW         = $clog2(SAMPLE_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_en,
  input  sync_mode_e       sync_mode,
  input  logic [WW-1:0]    sample_bits,
  input  logic [LEN_W-1:0] frame_bits,
  output logic             frame_start,
  output logic             fs,
  output logic             in_data,
  output logic             first_bit,
  output logic             last_bit,
  output logic [WW-1:0]    bit_idx,
  output logic [WW-1:0]    lat_w
);
  localparam logic [LEN_W-1:0] ONE  = LEN_W'(1);
  localparam logic [LEN_W-1:0] LSYN = LEN_W'(LONG_SYNC);

  logic [WW-1:0]    w_req;
  logic [LEN_W-1:0] w_len, len_min, len_req;
  logic             live;
  logic [LEN_W-1:0] slot, lat_len;
  sync_mode_e       lat_mode;
  logic [LEN_W-1:0] lat_wl, d_off, offs, idx_full;

  // Requested width and length, limited to the legal range
  always_comb begin
    if (sample_bits < WW'(SAMPLE_MIN))      w_req = WW'(SAMPLE_MIN);
    else if (sample_bits > WW'(SAMPLE_MAX)) w_req = WW'(SAMPLE_MAX);
    else                                    w_req = sample_bits;
    w_len = LEN_W'(w_req);
    if (sync_mode == SYNC_LONG) len_min = (w_len > LSYN) ? w_len : LSYN;
    else                        len_min = w_len + ONE;
    len_req = (frame_bits < len_min) ? len_min : frame_bits;
  end

  assign frame_start = bclk_en && (!live || slot == lat_len - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live     <= 1'b0;
      slot     <= '0;
      lat_len  <= '0;
      lat_w    <= '0;
      lat_mode <= SYNC_SHORT;
    end else if (frame_start) begin
      live     <= 1'b1;
      slot     <= '0;
      lat_len  <= len_req;
      lat_w    <= w_req;
      lat_mode <= sync_mode;
    end else if (bclk_en) begin
      slot <= slot + ONE;
    end
  end

  always_comb begin
    lat_wl    = LEN_W'(lat_w);
    d_off     = (lat_mode == SYNC_LONG) ? '0 : ONE;
    offs      = slot - d_off;
    idx_full  = lat_wl - ONE - offs;
    bit_idx   = idx_full[WW-1:0];
    in_data   = live && (slot >= d_off) && (slot < d_off + lat_wl);
    first_bit = in_data && (slot == d_off);
    last_bit  = in_data && (slot == d_off + lat_wl - ONE);
    fs        = live && ((lat_mode == SYNC_LONG) ? (slot < LSYN) : (slot == '0));
  end

  // R5
  len_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (lat_len >= lat_wl + d_off) && (lat_mode != SYNC_LONG || lat_len >= LSYN));

  // R5
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> slot < lat_len);

  // R2
  short_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fs && lat_mode == SYNC_SHORT && bclk_en) |=> !fs);

  // R10
  hold_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bclk_en |=> $stable(slot) && $stable(live));
endmodule

// File: rtl/pcm_tx_serializer.sv
module pcm_tx_serializer #(
  parameter int unsigned SAMPLE_MAX = 16,
  parameter int unsigned WW         = $clog2(SAMPLE_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  load_valid,
  input  logic [SAMPLE_MAX-1:0] load_data,
  input  logic                  in_data,
  input  logic [WW-1:0]         bit_idx,
  output logic                  sd
);
  logic [SAMPLE_MAX-1:0] word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word <= '0;
    else if (load) word <= load_valid ? load_data : '0;
  end

  assign sd = in_data && word[bit_idx];

  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !load_valid) |=> !sd);
endmodule

// File: rtl/pcm_rx_deserializer.sv
module pcm_rx_deserializer #(
  parameter int unsigned SAMPLE_MAX = 16,
  parameter int unsigned WW         = $clog2(SAMPLE_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  in_data,
  input  logic                  first_bit,
  input  logic                  last_bit,
  input  logic [WW-1:0]         lat_w,
  input  logic                  sd_in,
  output logic [SAMPLE_MAX-1:0] rx_data,
  output logic                  rx_valid
);
  logic [SAMPLE_MAX-1:0] acc, acc_next, ext;

  always_comb begin
    acc_next = first_bit ? {{(SAMPLE_MAX-1){1'b0}}, sd_in}
                         : {acc[SAMPLE_MAX-2:0], sd_in};
    for (int i = 0; i < SAMPLE_MAX; i++)
      ext[i] = (WW'(i) < lat_w) ? acc_next[i] : acc_next[lat_w - WW'(1)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= tick && last_bit;
      if (tick && in_data)  acc     <= acc_next;
      if (tick && last_bit) rx_data <= ext;
    end
  end

  // R8
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && last_bit) |=> $stable(rx_data));
endmodule

// File: rtl/pcm_sync_link.sv
module pcm_sync_link
  import pcm_link_pkg::*;
#(
  parameter int unsigned SAMPLE_MIN = 8,
  parameter int unsigned SAMPLE_MAX = 16,
  parameter int unsigned LEN_W      = 8,
  parameter int unsigned LONG_SYNC  = 13,
  parameter int unsigned WW         = $clog2(SAMPLE_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bclk_en,
  input  logic                  long_mode,
  input  logic [WW-1:0]         sample_bits,
  input  logic [LEN_W-1:0]      frame_bits,
  input  logic [SAMPLE_MAX-1:0] tx_data,
  input  logic                  tx_valid,
  output logic                  tx_ready,
  output logic                  fs_out,
  output logic                  sd_out,
  input  logic                  sd_in,
  output logic [SAMPLE_MAX-1:0] rx_data,
  output logic                  rx_valid
);
  logic          frame_start, in_data, first_bit, last_bit;
  logic [WW-1:0] bit_idx, lat_w;
  sync_mode_e    mode;

  assign mode     = sync_mode_e'(long_mode);
  assign tx_ready = frame_start;

  pcm_frame_timer #(
    .SAMPLE_MIN(SAMPLE_MIN), .SAMPLE_MAX(SAMPLE_MAX), .LEN_W(LEN_W),
    .LONG_SYNC(LONG_SYNC), .WW(WW)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .sync_mode(mode),
    .sample_bits(sample_bits), .frame_bits(frame_bits),
    .frame_start(frame_start), .fs(fs_out), .in_data(in_data),
    .first_bit(first_bit), .last_bit(last_bit), .bit_idx(bit_idx), .lat_w(lat_w)
  );

  pcm_tx_serializer #(.SAMPLE_MAX(SAMPLE_MAX), .WW(WW)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(frame_start), .load_valid(tx_valid),
    .load_data(tx_data), .in_data(in_data), .bit_idx(bit_idx), .sd(sd_out)
  );

  pcm_rx_deserializer #(.SAMPLE_MAX(SAMPLE_MAX), .WW(WW)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(bclk_en), .in_data(in_data),
    .first_bit(first_bit), .last_bit(last_bit), .lat_w(lat_w),
    .sd_in(sd_in), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  // R7
  ready_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> bclk_en);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> !fs_out && !sd_out && !rx_valid);
endmodule

// File: tb/pcm_sync_link_test.sv
module pcm_sync_link_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk_en = 1'b0;
  logic        long_mode = 1'b0;
  logic [4:0]  sample_bits = 5'd8;
  logic [7:0]  frame_bits = 8'd16;
  logic [15:0] tx_data = 16'h00A5;
  logic        tx_valid = 1'b0;
  logic        sd_in = 1'b0;
  logic        tx_ready, fs_out, sd_out, rx_valid;
  logic [15:0] rx_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit bclk_run = 1'b0;
  int bclk_div = 4;
  int bclk_cnt = 0;
  bit valid_en = 1'b1;
  int lfsr = 32'h1234_5678;

  // reference model state
  int q[$];
  bit cur_fs = 0, cur_sd = 0, cur_last = 0;
  bit exp_rxv = 0, took = 0;
  logic [15:0] exp_rxd = '0, frame_sext = '0;

  always #4 clk = ~clk;

  pcm_sync_link uut (
    .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .long_mode(long_mode),
    .sample_bits(sample_bits), .frame_bits(frame_bits), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .fs_out(fs_out), .sd_out(sd_out),
    .sd_in(sd_in), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic build_frame();
    int w, d, len, lmin;
    logic [15:0] word;
    w = (sample_bits < 8) ? 8 : (sample_bits > 16) ? 16 : int'(sample_bits);
    if (long_mode) lmin = (w > 13) ? w : 13;
    else           lmin = w + 1;
    len  = (int'(frame_bits) < lmin) ? lmin : int'(frame_bits);
    d    = long_mode ? 0 : 1;
    took = tx_valid;
    word = tx_valid ? (tx_data & 16'((32'd1 << w) - 1)) : 16'h0;
    frame_sext = word[w-1] ? (word | ~16'((32'd1 << w) - 1)) : word;
    for (int s = 0; s < len; s++) begin
      bit f, b, l;
      f = long_mode ? (s < 13) : (s == 0);
      b = (s >= d && s < d + w) ? word[w - 1 - (s - d)] : 1'b0;
      l = (s == d + w - 1);
      q.push_back({29'd0, f, b, l});
    end
  endtask

  // behavioural reference, one slot per bclk_en edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      cur_fs = 0; cur_sd = 0; cur_last = 0; exp_rxv = 0; took = 0;
    end else begin
      exp_rxv = 0;
      took = 0;
      if (bclk_en) begin
        int e;
        if (cur_last) begin
          exp_rxv = 1;
          exp_rxd = frame_sext;
        end
        if (q.size() == 0) build_frame();
        e = q.pop_front();
        cur_fs = e[2]; cur_sd = e[1]; cur_last = e[0];
      end
    end
  end

  // input drivers on the falling edge
  always @(negedge clk) begin
    if (bclk_run) begin
      bclk_en = (bclk_cnt == 0);
      bclk_cnt = (bclk_cnt + 1 >= bclk_div) ? 0 : bclk_cnt + 1;
    end else begin
      bclk_en = 1'b0;
      bclk_cnt = 0;
    end
    sd_in = sd_out;
    if (took) begin
      lfsr = lfsr * 1103515245 + 12345;
      tx_data = lfsr[23:8];
    end
    tx_valid = valid_en;
  end

  // compare every clock, 1 ns after the falling edge
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      check(fs_out === cur_fs, "R2 R3 R9 fs_out", fs_out, cur_fs);
      check(sd_out === cur_sd, "R4 R6 sd_out", sd_out, cur_sd);
      check(tx_ready === (bclk_en && q.size() == 0), "R5 R7 R10 tx_ready",
            tx_ready, (bclk_en && q.size() == 0));
      check(rx_valid === exp_rxv, "R8 rx_valid", rx_valid, exp_rxv);
      if (exp_rxv) check(rx_data === exp_rxd, "R8 rx_data", rx_data, exp_rxd);
    end
  end

  task automatic phase(input bit lm, input int sb, input int fb, input int div,
                       input bit ven, input int cycles);
    @(negedge clk);
    long_mode = lm;
    sample_bits = 5'(sb);
    frame_bits = 8'(fb);
    bclk_div = div;
    valid_en = ven;
    repeat (cycles) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    // R1: outputs quiet under reset
    check(fs_out === 1'b0 && sd_out === 1'b0 && rx_valid === 1'b0, "R1 reset outputs",
          {fs_out, sd_out, rx_valid}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    #2;
    // R10: no frame before the first bclk_en
    check(fs_out === 1'b0 && sd_out === 1'b0 && tx_ready === 1'b0, "R10 idle before tick",
          {fs_out, sd_out, tx_ready}, 0);
    bclk_run = 1'b1;
    phase(1'b0, 8, 16, 4, 1'b1, 700);   // R2 short sync, spare slots padded (R6)
    phase(1'b0, 16, 17, 4, 1'b1, 700);  // R5 minimum short length exactly
    phase(1'b0, 12, 5, 3, 1'b1, 500);   // R5 length raised
    phase(1'b1, 16, 32, 4, 1'b1, 900);  // R3 long sync
    phase(1'b1, 8, 4, 2, 1'b1, 500);    // R5 long floor 13
    phase(1'b1, 14, 14, 1, 1'b1, 300);  // LSB in the last slot, rx at frame start
    phase(1'b0, 3, 20, 4, 1'b0, 400);   // R4 width floor, R7 silence
    phase(1'b1, 25, 40, 4, 1'b1, 700);  // R4 width ceiling
    phase(1'b0, 10, 12, 1, 1'b1, 300);  // R9 mode change mid-frame
    repeat (20) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule